// File: doc/BRIEF.md
# Calendar Validate and BCD Pack

This block sits between a binary view of the wall-clock time and a battery-backed timekeeper that stores each field as two packed decimal digits. On the packing path, software hands over a full year, a month (1 to 12), a day, an hour, a minute and a second, together with a one-cycle start strobe. The block checks the whole date against a 100-year window and the Gregorian month lengths. On the next cycle it raises a valid pulse. If the input was acceptable, the pulse comes with six register bytes. If it was not, the pulse comes with an error flag.

The year is folded to two digits around 2000. From 2000 on, the stored value is the year minus 2000. Before 2000, the stored value is the year minus 1900.

A second, independent path takes six packed-decimal bytes read back from the device, again behind a start strobe. It returns binary fields one cycle later. The year comes back as years since 1900. The month comes back counted from zero.

Top module: `caltime_codec`

## Requirements
- R1: `pk_valid` is high in exactly the cycle after each cycle in which `pk_start` is sampled high, and low otherwise; back-to-back strobes give back-to-back pulses.
- R2: A year below 1970 or above 2069 sets `pk_error` with `pk_valid`.
- R3: A month of 0 or above 12, or a day of 0, sets `pk_error` with `pk_valid`.
- R4: A day beyond its month's length sets `pk_error`. The month lengths are 31 for January, March, May, July, August, October and December, 30 for April, June, September and November, and 28 for February. February has 29 days when the year is divisible by 400, or divisible by 4 but not by 100.
- R5: An hour of 24 or more, a minute of 60 or more, or a second of 60 or more sets `pk_error`.
- R6: For an accepted input, every output byte carries the tens digit in bits 7:4 and the units digit in bits 3:0. The year byte encodes year−2000 for years 2000 to 2069 and year−1900 for years 1970 to 1999.
- R7: `pk_error` is never high without `pk_valid`. When an input is rejected, all six packed outputs keep the values they held before.
- R8: `rb_valid` is high in exactly the cycle after each cycle in which `rb_start` is sampled high. The binary outputs are updated in that same cycle, as follows:
  - `rb_year` is the decoded two-digit year plus 100 when that year is 69 or below, and the decoded year unchanged otherwise.
  - `rb_month` is the decoded month minus one.
  - The day, hour, minute and second are the decoded values.
- R9: While `rst_n` is low, both valid flags and the error flag are low and every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_start | input | 1 | Strobe: validate and pack the binary inputs |
| pk_year | input | YEAR_W (12) | Full binary year |
| pk_month | input | 4 | Month, 1 to 12 |
| pk_day | input | 5 | Day of month |
| pk_hour | input | 5 | Hour, 0 to 23 |
| pk_min | input | 6 | Minute, 0 to 59 |
| pk_sec | input | 6 | Second, 0 to 59 |
| pk_valid | output | 1 | Pack result present |
| pk_error | output | 1 | Input rejected (only with pk_valid) |
| pk_sec_bcd | output | 8 | Packed second |
| pk_min_bcd | output | 8 | Packed minute |
| pk_hour_bcd | output | 8 | Packed hour |
| pk_day_bcd | output | 8 | Packed day |
| pk_mon_bcd | output | 8 | Packed month |
| pk_year_bcd | output | 8 | Packed two-digit year |
| rb_start | input | 1 | Strobe: unpack the read-back bytes |
| rb_sec_bcd | input | 8 | Read-back second byte |
| rb_min_bcd | input | 8 | Read-back minute byte |
| rb_hour_bcd | input | 8 | Read-back hour byte |
| rb_day_bcd | input | 8 | Read-back day byte |
| rb_mon_bcd | input | 8 | Read-back month byte |
| rb_year_bcd | input | 8 | Read-back two-digit year byte |
| rb_valid | output | 1 | Unpack result present |
| rb_year | output | 8 | Years since 1900 |
| rb_month | output | 4 | Zero-based month |
| rb_day | output | 5 | Day |
| rb_hour | output | 5 | Hour |
| rb_min | output | 6 | Minute |
| rb_sec | output | 6 | Second |

## Verification
Some properties hold on every cycle, and assertions check them continuously:
- the one-cycle strobe-to-valid relation on both paths;
- the rule that the error flag never appears without valid;
- the freeze of the packed bytes on a rejected input;
- the decimal-digit range of every nibble in an accepted result;
- the lower bound of 70 on the read-back year.

The other properties depend on the exact data, so only the bench scenarios can show them:
- whether a particular date is accepted or rejected, including February 29 in 2000, 2023 and 2024, the window edges 1969, 1970, 2069 and 2070, and a day 31 in a 30-day month;
- the exact packed bytes produced;
- the year fold and month shift on read-back.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NUM_FIELDS = 6;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;

   // length of a month in days; unused for month codes outside 1..12
   function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
      case (m)
         4'd2:                       return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
         default:                    return 5'd31;
      endcase
   endfunction

   // both nibbles are decimal digits
   function automatic logic bcd_ok(input logic [7:0] b);
      return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
   endfunction

endpackage

// File: rtl/cal_bin2bcd.sv
module cal_bin2bcd #(
   parameter int IN_W      = 7,
   parameter int DIGITS    = 2,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic [IN_W-1:0]     bin,
   output logic [4*DIGITS-1:0] bcd
);
   localparam int ACC_W = IN_W + 4*DIGITS;

   if (IN_W < 1 || DIGITS < 1) begin : g_bad_cfg
      $error("cal_bin2bcd: IN_W and DIGITS must be positive");
   end

   if (SHIFT_ADD) begin : g_shift_add
      logic [ACC_W-1:0] acc;
      always_comb begin
         acc = '0;
         acc[IN_W-1:0] = bin;
         for (int i = 0; i < IN_W; i++) begin
            for (int d = 0; d < DIGITS; d++) begin
               if (acc[IN_W+4*d +: 4] >= 4'd5)
                  acc[IN_W+4*d +: 4] = acc[IN_W+4*d +: 4] + 4'd3;
            end
            acc = acc << 1;
         end
         bcd = acc[IN_W +: 4*DIGITS];
      end
   end else begin : g_divide
      logic [IN_W-1:0] rem;
      always_comb begin
         rem = bin;
         bcd = '0;
         for (int d = 0; d < DIGITS; d++) begin
            bcd[4*d +: 4] = 4'(rem % IN_W'(10));
            rem = rem / IN_W'(10);
         end
      end
   end

endmodule

// File: rtl/cal_bcd2bin.sv
module cal_bcd2bin #(
   parameter int DIGITS = 2,
   parameter int OUT_W  = 8
) (
   input  logic [4*DIGITS-1:0] bcd,
   output logic [OUT_W-1:0]    bin
);
   if (OUT_W < 4 || DIGITS < 1) begin : g_bad_cfg
      $error("cal_bcd2bin: OUT_W too small or DIGITS not positive");
   end

   always_comb begin
      bin = '0;
      for (int d = DIGITS-1; d >= 0; d--) begin
         bin = bin * OUT_W'(10) + OUT_W'(bcd[4*d +: 4]);
      end
   end

endmodule

// File: rtl/cal_check.sv
module cal_check
   import cal_pkg::*;
#(
   parameter int YEAR_W    = 12,
   parameter int YEAR_LO   = 1970,
   parameter int YEAR_SPAN = 100,
   parameter int PIVOT     = 2000
) (
   input  logic [YEAR_W-1:0] year,
   input  logic [3:0]        month,
   input  logic [4:0]        day,
   input  logic [4:0]        hour,
   input  logic [5:0]        minute,
   input  logic [5:0]        second,
   output logic              bad,
   output logic [6:0]        year2
);
   localparam int YEAR_HI      = YEAR_LO + YEAR_SPAN - 1;
   localparam int CENTURY_BASE = PIVOT - 100;

   if (YEAR_SPAN < 1 || YEAR_SPAN > 100) begin : g_bad_span
      $error("cal_check: YEAR_SPAN must be 1..100");
   end
   if (YEAR_LO < CENTURY_BASE || YEAR_HI >= PIVOT + 100) begin : g_bad_window
      $error("cal_check: window must fit the two-digit fold around PIVOT");
   end
   if (YEAR_HI >= (1 << YEAR_W)) begin : g_bad_width
      $error("cal_check: YEAR_W too narrow for the window");
   end

   logic              leap;
   logic [4:0]        day_lim;
   logic              year_bad, date_bad, clock_bad;
   logic [YEAR_W-1:0] year_fold;

   always_comb begin
      leap = ((year % YEAR_W'(4)) == '0 && (year % YEAR_W'(100)) != '0)
          || ((year % YEAR_W'(400)) == '0);
      day_lim   = month_len(month, leap);
      year_bad  = (year < YEAR_W'(YEAR_LO)) || (year > YEAR_W'(YEAR_HI));
      date_bad  = (month == 4'd0) || (month > 4'd12) || (day == 5'd0) || (day > day_lim);
      clock_bad = (hour >= 5'd24) || (minute >= 6'd60) || (second >= 6'd60);
      bad       = year_bad || date_bad || clock_bad;
      year_fold = (year >= YEAR_W'(PIVOT)) ? year - YEAR_W'(PIVOT)
                                           : year - YEAR_W'(CENTURY_BASE);
      year2     = year_fold[6:0];
   end

endmodule

// File: rtl/cal_pack.sv
module cal_pack
   import cal_pkg::*;
#(
   parameter int YEAR_W    = 12,
   parameter int YEAR_LO   = 1970,
   parameter int YEAR_SPAN = 100,
   parameter int PIVOT     = 2000,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [YEAR_W-1:0] year,
   input  logic [3:0]        month,
   input  logic [4:0]        day,
   input  logic [4:0]        hour,
   input  logic [5:0]        minute,
   input  logic [5:0]        second,
   output logic              valid,
   output logic              err,
   output logic [7:0]        bcd_q [NUM_FIELDS]
);
   logic       bad;
   logic [6:0] year2;
   logic [6:0] bin_f [NUM_FIELDS];
   logic [7:0] bcd_f [NUM_FIELDS];

   cal_check #(
      .YEAR_W(YEAR_W), .YEAR_LO(YEAR_LO), .YEAR_SPAN(YEAR_SPAN), .PIVOT(PIVOT)
   ) u_check (
      .year(year), .month(month), .day(day), .hour(hour),
      .minute(minute), .second(second), .bad(bad), .year2(year2)
   );

   assign bin_f[F_SEC]  = {1'b0, second};
   assign bin_f[F_MIN]  = {1'b0, minute};
   assign bin_f[F_HOUR] = {2'b0, hour};
   assign bin_f[F_DAY]  = {2'b0, day};
   assign bin_f[F_MON]  = {3'b0, month};
   assign bin_f[F_YEAR] = year2;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      cal_bin2bcd #(.IN_W(7), .DIGITS(2), .SHIFT_ADD(SHIFT_ADD)) u_b2d (
         .bin(bin_f[f]), .bcd(bcd_f[f])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         err   <= 1'b0;
         for (int f = 0; f < NUM_FIELDS; f++) bcd_q[f] <= '0;
      end else begin
         valid <= start;
         err   <= start && bad;
         if (start && !bad) begin
            for (int f = 0; f < NUM_FIELDS; f++) bcd_q[f] <= bcd_f[f];
         end
      end
   end

   a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);
   a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);
   a_r7_error_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> valid);
   a_r7_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(bcd_q[F_SEC]) && $stable(bcd_q[F_MIN]) && $stable(bcd_q[F_HOUR])
            && $stable(bcd_q[F_DAY]) && $stable(bcd_q[F_MON]) && $stable(bcd_q[F_YEAR])));
   a_r6_decimal_digits: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !err) |-> (bcd_ok(bcd_q[F_SEC]) && bcd_ok(bcd_q[F_MIN]) && bcd_ok(bcd_q[F_HOUR])
                        && bcd_ok(bcd_q[F_DAY]) && bcd_ok(bcd_q[F_MON]) && bcd_ok(bcd_q[F_YEAR])));

endmodule

// File: rtl/cal_unpack.sv
module cal_unpack
   import cal_pkg::*;
#(
   parameter int YEAR_LO = 1970,
   parameter int PIVOT   = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] bcd_in [NUM_FIELDS],
   output logic       valid,
   output logic [7:0] year_since,
   output logic [3:0] month0,
   output logic [4:0] day,
   output logic [4:0] hour,
   output logic [5:0] minute,
   output logic [5:0] second
);
   localparam int FOLD_MAX = YEAR_LO - (PIVOT - 100) - 1;

   if (FOLD_MAX < 0 || FOLD_MAX > 99) begin : g_bad_fold
      $error("cal_unpack: window start must lie within the century before PIVOT");
   end

   logic [7:0] bin_f [NUM_FIELDS];
   logic [7:0] year_n;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      cal_bcd2bin #(.DIGITS(2), .OUT_W(8)) u_d2b (
         .bcd(bcd_in[f]), .bin(bin_f[f])
      );
   end

   assign year_n = (bin_f[F_YEAR] <= 8'(FOLD_MAX)) ? bin_f[F_YEAR] + 8'd100
                                                   : bin_f[F_YEAR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid      <= 1'b0;
         year_since <= '0;
         month0     <= '0;
         day        <= '0;
         hour       <= '0;
         minute     <= '0;
         second     <= '0;
      end else begin
         valid <= start;
         if (start) begin
            year_since <= year_n;
            month0     <= 4'(bin_f[F_MON] - 8'd1);
            day        <= 5'(bin_f[F_DAY]);
            hour       <= 5'(bin_f[F_HOUR]);
            minute     <= 6'(bin_f[F_MIN]);
            second     <= 6'(bin_f[F_SEC]);
         end
      end
   end

   a_r8_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);
   a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);
   a_r8_year_floor: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (year_since >= 8'(FOLD_MAX + 1)));

endmodule

// File: rtl/caltime_codec.sv
module caltime_codec
   import cal_pkg::*;
#(
   parameter int YEAR_W    = 12,
   parameter int YEAR_LO   = 1970,
   parameter int YEAR_SPAN = 100,
   parameter int PIVOT     = 2000,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pk_start,
   input  logic [YEAR_W-1:0] pk_year,
   input  logic [3:0]        pk_month,
   input  logic [4:0]        pk_day,
   input  logic [4:0]        pk_hour,
   input  logic [5:0]        pk_min,
   input  logic [5:0]        pk_sec,
   output logic              pk_valid,
   output logic              pk_error,
   output logic [7:0]        pk_sec_bcd,
   output logic [7:0]        pk_min_bcd,
   output logic [7:0]        pk_hour_bcd,
   output logic [7:0]        pk_day_bcd,
   output logic [7:0]        pk_mon_bcd,
   output logic [7:0]        pk_year_bcd,
   input  logic              rb_start,
   input  logic [7:0]        rb_sec_bcd,
   input  logic [7:0]        rb_min_bcd,
   input  logic [7:0]        rb_hour_bcd,
   input  logic [7:0]        rb_day_bcd,
   input  logic [7:0]        rb_mon_bcd,
   input  logic [7:0]        rb_year_bcd,
   output logic              rb_valid,
   output logic [7:0]        rb_year,
   output logic [3:0]        rb_month,
   output logic [4:0]        rb_day,
   output logic [4:0]        rb_hour,
   output logic [5:0]        rb_min,
   output logic [5:0]        rb_sec
);
   logic [7:0] pk_bcd [NUM_FIELDS];
   logic [7:0] rb_bcd [NUM_FIELDS];

   cal_pack #(
      .YEAR_W(YEAR_W), .YEAR_LO(YEAR_LO), .YEAR_SPAN(YEAR_SPAN),
      .PIVOT(PIVOT), .SHIFT_ADD(SHIFT_ADD)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .start(pk_start),
      .year(pk_year), .month(pk_month), .day(pk_day), .hour(pk_hour),
      .minute(pk_min), .second(pk_sec),
      .valid(pk_valid), .err(pk_error), .bcd_q(pk_bcd)
   );

   assign pk_sec_bcd  = pk_bcd[F_SEC];
   assign pk_min_bcd  = pk_bcd[F_MIN];
   assign pk_hour_bcd = pk_bcd[F_HOUR];
   assign pk_day_bcd  = pk_bcd[F_DAY];
   assign pk_mon_bcd  = pk_bcd[F_MON];
   assign pk_year_bcd = pk_bcd[F_YEAR];

   assign rb_bcd[F_SEC]  = rb_sec_bcd;
   assign rb_bcd[F_MIN]  = rb_min_bcd;
   assign rb_bcd[F_HOUR] = rb_hour_bcd;
   assign rb_bcd[F_DAY]  = rb_day_bcd;
   assign rb_bcd[F_MON]  = rb_mon_bcd;
   assign rb_bcd[F_YEAR] = rb_year_bcd;

   cal_unpack #(.YEAR_LO(YEAR_LO), .PIVOT(PIVOT)) u_unpack (
      .clk(clk), .rst_n(rst_n), .start(rb_start), .bcd_in(rb_bcd),
      .valid(rb_valid), .year_since(rb_year), .month0(rb_month),
      .day(rb_day), .hour(rb_hour), .minute(rb_min), .second(rb_sec)
   );

endmodule

// File: tb/tb_caltime_codec.sv
module tb_caltime_codec;

   typedef struct {
      logic        err;
      logic [47:0] bcd;
      string       tag;
   } pk_exp_t;

   typedef struct {
      logic [33:0] val;
      string       tag;
   } rb_exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pk_start = 1'b0;
   logic [11:0] pk_year = '0;
   logic [3:0]  pk_month = '0;
   logic [4:0]  pk_day = '0, pk_hour = '0;
   logic [5:0]  pk_min = '0, pk_sec = '0;
   logic        pk_valid, pk_error;
   logic [7:0]  pk_sec_bcd, pk_min_bcd, pk_hour_bcd, pk_day_bcd, pk_mon_bcd, pk_year_bcd;
   logic        rb_start = 1'b0;
   logic [7:0]  rb_sec_bcd = '0, rb_min_bcd = '0, rb_hour_bcd = '0;
   logic [7:0]  rb_day_bcd = '0, rb_mon_bcd = '0, rb_year_bcd = '0;
   logic        rb_valid;
   logic [7:0]  rb_year;
   logic [3:0]  rb_month;
   logic [4:0]  rb_day, rb_hour;
   logic [5:0]  rb_min, rb_sec;

   int tests = 0;
   int fails = 0;
   bit done  = 0;
   pk_exp_t pk_q[$];
   rb_exp_t rb_q[$];
   logic [47:0] last_good = '0;

   always #10 clk = ~clk;

   caltime_codec dut (
      .clk(clk), .rst_n(rst_n),
      .pk_start(pk_start), .pk_year(pk_year), .pk_month(pk_month), .pk_day(pk_day),
      .pk_hour(pk_hour), .pk_min(pk_min), .pk_sec(pk_sec),
      .pk_valid(pk_valid), .pk_error(pk_error),
      .pk_sec_bcd(pk_sec_bcd), .pk_min_bcd(pk_min_bcd), .pk_hour_bcd(pk_hour_bcd),
      .pk_day_bcd(pk_day_bcd), .pk_mon_bcd(pk_mon_bcd), .pk_year_bcd(pk_year_bcd),
      .rb_start(rb_start), .rb_sec_bcd(rb_sec_bcd), .rb_min_bcd(rb_min_bcd),
      .rb_hour_bcd(rb_hour_bcd), .rb_day_bcd(rb_day_bcd), .rb_mon_bcd(rb_mon_bcd),
      .rb_year_bcd(rb_year_bcd),
      .rb_valid(rb_valid), .rb_year(rb_year), .rb_month(rb_month), .rb_day(rb_day),
      .rb_hour(rb_hour), .rb_min(rb_min), .rb_sec(rb_sec)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) % 10) * 16 + (v % 10));
   endfunction

   function automatic int days_of(input int y, input int m);
      bit leap;
      leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
      case (m)
         2:           return leap ? 29 : 28;
         4, 6, 9, 11: return 30;
         default:     return 31;
      endcase
   endfunction

   // driver for the pack path: called at a falling edge, holds start for one cycle
   task automatic pk_op(input int y, input int mo, input int d, input int h,
                        input int mi, input int s, input string tag);
      pk_exp_t e;
      bit bad;
      int yy;
      bad = (y < 1970) || (y > 2069) || (mo < 1) || (mo > 12) || (d < 1)
         || (d > days_of(y, mo)) || (h >= 24) || (mi >= 60) || (s >= 60);
      yy = (y >= 2000) ? y - 2000 : y - 1900;
      if (!bad)
         last_good = {to_bcd(yy), to_bcd(mo), to_bcd(d), to_bcd(h), to_bcd(mi), to_bcd(s)};
      e.err = bad;
      e.bcd = last_good;
      e.tag = tag;
      pk_q.push_back(e);
      pk_year  = 12'(y);
      pk_month = 4'(mo);
      pk_day   = 5'(d);
      pk_hour  = 5'(h);
      pk_min   = 6'(mi);
      pk_sec   = 6'(s);
      pk_start = 1'b1;
      @(negedge clk);
   endtask

   task automatic rb_op(input int yb, input int mb, input int d, input int h,
                        input int mi, input int s, input string tag);
      rb_exp_t e;
      int yr;
      yr = (yb <= 69) ? yb + 100 : yb;
      e.val = {8'(yr), 4'(mb - 1), 5'(d), 5'(h), 6'(mi), 6'(s)};
      e.tag = tag;
      rb_q.push_back(e);
      rb_year_bcd = to_bcd(yb);
      rb_mon_bcd  = to_bcd(mb);
      rb_day_bcd  = to_bcd(d);
      rb_hour_bcd = to_bcd(h);
      rb_min_bcd  = to_bcd(mi);
      rb_sec_bcd  = to_bcd(s);
      rb_start    = 1'b1;
      @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (pk_valid) begin
            if (pk_q.size() == 0) begin
               check(1'b0, "R1 unexpected pk_valid", 64'(pk_valid), 64'(0));
            end else begin
               pk_exp_t e;
               e = pk_q.pop_front();
               check(pk_error === e.err, {e.tag, " error flag"}, 64'(pk_error), 64'(e.err));
               check({pk_year_bcd, pk_mon_bcd, pk_day_bcd, pk_hour_bcd, pk_min_bcd, pk_sec_bcd} === e.bcd,
                     {e.tag, e.err ? " R7 hold" : " R6 bytes"},
                     64'({pk_year_bcd, pk_mon_bcd, pk_day_bcd, pk_hour_bcd, pk_min_bcd, pk_sec_bcd}),
                     64'(e.bcd));
            end
         end
         if (rb_valid) begin
            if (rb_q.size() == 0) begin
               check(1'b0, "R8 unexpected rb_valid", 64'(rb_valid), 64'(0));
            end else begin
               rb_exp_t e;
               e = rb_q.pop_front();
               check({rb_year, rb_month, rb_day, rb_hour, rb_min, rb_sec} === e.val, e.tag,
                     64'({rb_year, rb_month, rb_day, rb_hour, rb_min, rb_sec}), 64'(e.val));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check({pk_valid, pk_error, rb_valid} === 3'b000, "R9 flags in reset",
            64'({pk_valid, pk_error, rb_valid}), 64'(0));
      check({pk_year_bcd, pk_mon_bcd, pk_day_bcd, pk_hour_bcd, pk_min_bcd, pk_sec_bcd} === 48'h0,
            "R9 packed bytes in reset",
            64'({pk_year_bcd, pk_mon_bcd, pk_day_bcd, pk_hour_bcd, pk_min_bcd, pk_sec_bcd}), 64'(0));
      check({rb_year, rb_month, rb_day, rb_hour, rb_min, rb_sec} === 34'h0, "R9 read-back in reset",
            64'({rb_year, rb_month, rb_day, rb_hour, rb_min, rb_sec}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // back-to-back pack requests (R1, R6) and rejections (R2..R5, R7)
      pk_op(2024, 2, 29, 12, 34, 56, "R4 leap 2024");
      pk_op(1999, 12, 31, 23, 59, 59, "R6 pre-2000 fold");
      pk_op(1969, 12, 31, 23, 59, 59, "R2 year 1969");
      pk_op(1970, 1, 1, 0, 0, 0, "R2 year 1970");
      pk_op(2070, 1, 1, 0, 0, 0, "R2 year 2070");
      pk_op(2069, 6, 30, 7, 8, 9, "R2 year 2069");
      pk_op(2000, 2, 29, 1, 2, 3, "R4 leap 2000");
      pk_op(2023, 2, 29, 1, 2, 3, "R4 non-leap 2023");
      pk_op(2023, 2, 28, 4, 5, 6, "R4 Feb 28 2023");
      pk_op(2010, 0, 10, 1, 1, 1, "R3 month 0");
      pk_op(2010, 13, 10, 1, 1, 1, "R3 month 13");
      pk_op(2010, 5, 0, 1, 1, 1, "R3 day 0");
      pk_op(2010, 4, 31, 1, 1, 1, "R4 April 31");
      pk_op(2010, 10, 31, 10, 20, 30, "R4 October 31");
      pk_op(2010, 5, 5, 24, 0, 0, "R5 hour 24");
      pk_op(2010, 5, 5, 0, 60, 0, "R5 minute 60");
      pk_op(2010, 5, 5, 0, 0, 60, "R5 second 60");
      pk_op(2005, 9, 9, 23, 59, 59, "R6 year 2005");
      pk_start = 1'b0;
      repeat (2) @(negedge clk);
      // R1: no pulse without a strobe
      check(pk_valid === 1'b0, "R1 idle valid", 64'(pk_valid), 64'(0));
      check(pk_error === 1'b0, "R7 idle error", 64'(pk_error), 64'(0));

      // read-back path (R8)
      rb_op(24, 2, 29, 12, 34, 56, "R8 year 24");
      rb_op(99, 12, 31, 23, 59, 59, "R8 year 99");
      rb_op(69, 1, 1, 0, 0, 0, "R8 year 69");
      rb_op(70, 7, 4, 5, 6, 7, "R8 year 70");
      rb_op(0, 10, 15, 8, 9, 10, "R8 year 00");
      rb_start = 1'b0;
      repeat (2) @(negedge clk);
      check(rb_valid === 1'b0, "R8 idle valid", 64'(rb_valid), 64'(0));

      check(pk_q.size() == 0 && rb_q.size() == 0, "R1 R8 missing results",
            64'(pk_q.size() + rb_q.size()), 64'(0));

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule